// File: doc/BRIEF.md
# Byte-Parity SRAM with Error Capture and Fault Injection

This block wraps a word-organised on-chip memory. Each stored byte carries one parity bit, chosen so the byte and its bit together hold an even number of ones. A byte-masked write recomputes parity only for the byte lanes it writes. Every read compares the stored bits with the returned data. If any lane disagrees, a single-cycle error pulse is raised alongside the read data. The byte offset of the failing word, which is always word-aligned, is then latched into a status register that software can read.

A small register port holds three registers. The control register has a capture-hold bit and an injection-enable bit. The status register holds the captured offset. The injection register holds one target word offset. While injection is enabled, any write to the target word stores inverted parity on the lanes it writes. Later reads of that word then fail, which lets software exercise the error path without a real fault. The corruption stays in place until the lanes are rewritten with injection off. Capture hold freezes the status register but does not stop the error pulse.

Top module: `par_sram`

## Requirements
- R1: After reset the control, status and injection registers all read as zero and the error pulse is low.
- R2: The control register at byte offset 0x0 stores bits 8:0 as written: bit 8 is capture hold and bit 0 is injection enable. Bits 31:9 read as zero.
- R3: The injection register at 0x8 stores a 24-bit offset in bits 23:0. The status register at 0x4 is read-only, and writes to it have no effect. Bits 31:24 of every register read as zero, and unmapped offset 0xC reads as zero.
- R4: A read issued in one cycle returns the stored word on the read data output after the next clock edge.
- R5: A write updates only the byte lanes whose byte-enable bit is set. Lane i is data bits 8i+7:8i.
- R6: A word written while injection is disabled, or not at the target offset, reads back with no error pulse.
- R7: While injection is enabled, a write whose byte offset (word index times 4) equals the full 24-bit injection offset stores inverted parity on its written lanes. A later read of that word raises the error pulse. An offset with bits 1:0 nonzero matches no word.
- R8: Writes to words other than the injection target are stored with correct parity.
- R9: Inverted parity persists after injection is disabled. It is cleared lane by lane only when those lanes are rewritten with injection off.
- R10: When the error pulse rises and capture hold is 0, the status register shows the failing word's byte offset from the next clock edge. Otherwise the status register keeps its value.
- R11: With capture hold set, a failing read still raises the error pulse, but the status register is left unchanged.
- R12: The error pulse lasts exactly the cycle in which the read data is valid. It is raised once per failing read, however many lanes fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regEn | input | 1 | Register access strobe |
| regWr | input | 1 | Register access is a write |
| regAddr | input | 4 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational from regAddr |
| memEn | input | 1 | Memory access strobe |
| memWr | input | 1 | Memory access is a write |
| memAddr | input | ADDR_W | Word index |
| memBe | input | DATA_W/8 | Byte-lane write enables |
| memWdata | input | DATA_W | Memory write data |
| memRdata | output | DATA_W | Memory read data, one cycle after the read |
| parErr | output | 1 | Parity error pulse, aligned with memRdata |

## Verification
The parity error is the hardest condition to reach from the ports, because clean data always carries correct parity. The stimulus reaches it only by arming injection at a chosen word and writing that word, sometimes with a partial byte mask so that only some lanes are corrupted. Capture hold is then toggled around reads of the corrupted words, to separate detection from capture. Partial rewrites after injection is disabled check that the corruption clears lane by lane.

// File: rtl/par_sram_pkg.sv
package par_sram_pkg;
  localparam int REG_W   = 32;
  localparam int OFF_W   = 24;
  localparam int CTRL_W  = 9;
  localparam int INJ_BIT  = 0;
  localparam int HOLD_BIT = 8;
  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_CAPT = 4'h4;
  localparam logic [3:0] OFS_INJ  = 4'h8;

  typedef struct packed {
    logic doWrite;
    logic doRead;
    logic flipPar;
  } memStrobe_t;
endpackage

// File: rtl/par_sram_ctrl.sv
module par_sram_ctrl
  import par_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regEn,
  input  logic                regWr,
  input  logic [3:0]          regAddr,
  input  logic [REG_W-1:0]    regWdata,
  output logic [REG_W-1:0]    regRdata,
  input  logic                memEn,
  input  logic                memWr,
  input  logic [ADDR_W-1:0]   memAddr,
  input  logic                errPulse,
  input  logic [OFF_W-1:0]    errOff,
  output memStrobe_t          strobe,
  output logic [OFF_W-1:0]    capAddr,
  output logic                capHold
);
  logic [CTRL_W-1:0] ctrlQ;
  logic [OFF_W-1:0]  injOffQ;
  logic [OFF_W-1:0]  captQ;
  logic [OFF_W-1:0]  memOff;
  logic              regWrite;

  assign regWrite = regEn & regWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      injOffQ <= '0;
      captQ   <= '0;
    end else begin
      if (regWrite && regAddr == OFS_CTRL) ctrlQ   <= regWdata[CTRL_W-1:0];
      if (regWrite && regAddr == OFS_INJ)  injOffQ <= regWdata[OFF_W-1:0];
      if (errPulse && !ctrlQ[HOLD_BIT])    captQ   <= errOff;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      OFS_CTRL: regRdata[CTRL_W-1:0] = ctrlQ;
      OFS_CAPT: regRdata[OFF_W-1:0]  = captQ;
      OFS_INJ:  regRdata[OFF_W-1:0]  = injOffQ;
      default:  regRdata = '0;
    endcase
  end

  always_comb begin
    memOff = '0;
    memOff[ADDR_W+1:0] = {memAddr, 2'b00};
  end

  always_comb begin
    strobe.doWrite = memEn & memWr;
    strobe.doRead  = memEn & ~memWr;
    strobe.flipPar = memEn & memWr & ctrlQ[INJ_BIT] & (memOff == injOffQ);
  end

  assign capAddr = captQ;
  assign capHold = ctrlQ[HOLD_BIT];
endmodule

// File: rtl/par_sram_dp.sv
module par_sram_dp
  import par_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  memStrobe_t          strobe,
  input  logic [ADDR_W-1:0]   memAddr,
  input  logic [DATA_W/8-1:0] memBe,
  input  logic [DATA_W-1:0]   memWdata,
  output logic [DATA_W-1:0]   memRdata,
  output logic                parErr,
  output logic [OFF_W-1:0]    errOff
);
  localparam int NB    = DATA_W / 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] dataArr [DEPTH];
  logic [NB-1:0]     parArr  [DEPTH];
  logic [NB-1:0]     wrPar;
  logic [NB-1:0]     laneBad;
  logic [DATA_W-1:0] rdData;
  logic [NB-1:0]     rdPar;
  logic [ADDR_W-1:0] rdAddr;
  logic              rdValid;

  for (genvar lane = 0; lane < NB; lane++) begin : gLane
    assign wrPar[lane]   = (^memWdata[lane*8 +: 8]) ^ strobe.flipPar;
    assign laneBad[lane] = (^rdData[lane*8 +: 8]) != rdPar[lane];
  end

  always_ff @(posedge clk) begin
    if (strobe.doWrite) begin
      for (int b = 0; b < NB; b++) begin
        if (memBe[b]) begin
          dataArr[memAddr][b*8 +: 8] <= memWdata[b*8 +: 8];
          parArr[memAddr][b]         <= wrPar[b];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdAddr  <= '0;
      rdData  <= '0;
      rdPar   <= '0;
    end else begin
      rdValid <= strobe.doRead;
      if (strobe.doRead) begin
        rdAddr <= memAddr;
        rdData <= dataArr[memAddr];
        rdPar  <= parArr[memAddr];
      end
    end
  end

  always_comb begin
    errOff = '0;
    errOff[ADDR_W+1:0] = {rdAddr, 2'b00};
  end

  assign memRdata = rdData;
  assign parErr   = rdValid & (|laneBad);
endmodule

// File: rtl/par_sram.sv
module par_sram
  import par_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regEn,
  input  logic                regWr,
  input  logic [3:0]          regAddr,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  input  logic                memEn,
  input  logic                memWr,
  input  logic [ADDR_W-1:0]   memAddr,
  input  logic [DATA_W/8-1:0] memBe,
  input  logic [DATA_W-1:0]   memWdata,
  output logic [DATA_W-1:0]   memRdata,
  output logic                parErr
);
  memStrobe_t       strobe;
  logic [OFF_W-1:0] errOff;
  logic [OFF_W-1:0] capAddr;
  logic             capHold;

  par_sram_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .regEn(regEn), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .memEn(memEn), .memWr(memWr), .memAddr(memAddr),
    .errPulse(parErr), .errOff(errOff),
    .strobe(strobe), .capAddr(capAddr), .capHold(capHold)
  );

  par_sram_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .memAddr(memAddr), .memBe(memBe), .memWdata(memWdata),
    .memRdata(memRdata), .parErr(parErr), .errOff(errOff)
  );
endmodule

// File: rtl/par_sram_chk.sv
module par_sram_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memEn,
  input logic        memWr,
  input logic        parErr,
  input logic [31:0] regRdata,
  input logic        capHold,
  input logic [23:0] capAddr,
  input logic [23:0] errOff
);
  AST_ERR_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    parErr |-> $past(memEn && !memWr)); // R12
  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rstN)
    capHold |=> $stable(capAddr)); // R11
  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (parErr && !capHold) |=> (capAddr == $past(errOff))); // R10
  AST_CAPTURE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !parErr |=> $stable(capAddr)); // R10
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    regRdata[31:24] == 8'h00); // R3
endmodule

bind par_sram par_sram_chk uChk (
  .clk(clk), .rstN(rstN), .memEn(memEn), .memWr(memWr), .parErr(parErr),
  .regRdata(regRdata), .capHold(capHold), .capAddr(capAddr), .errOff(errOff)
);

// File: tb/sim_par_sram.sv
`timescale 1ns/1ps
module sim_par_sram;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int NB = DW / 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regEn = 0, regWr = 0;
  logic [3:0] regAddr = 0;
  logic [31:0] regWdata = 0;
  logic [31:0] regRdata;
  logic memEn = 0, memWr = 0;
  logic [AW-1:0] memAddr = 0;
  logic [NB-1:0] memBe = 0;
  logic [DW-1:0] memWdata = 0;
  logic [DW-1:0] memRdata;
  logic parErr;

  always #2 clk = ~clk;

  par_sram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .regEn(regEn), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .memEn(memEn), .memWr(memWr),
    .memAddr(memAddr), .memBe(memBe), .memWdata(memWdata),
    .memRdata(memRdata), .parErr(parErr)
  );

  int total = 0;
  int fails = 0;

  logic [DW-1:0] refData [DEPTH];
  logic [NB-1:0] refBad  [DEPTH];
  logic          mInj = 0, mHold = 0;
  logic [23:0]   mInjOff = 0;
  logic [23:0]   mCapt = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regEn = 1; regWr = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regEn = 0; regWr = 0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regEn = 1; regWr = 0; regAddr = a;
    #1 d = regRdata;
    regEn = 0;
  endtask

  task automatic setCtrl(input logic [31:0] v);
    regWrite(4'h0, v);
    mInj = v[0]; mHold = v[8];
  endtask

  task automatic setInj(input logic [31:0] v);
    regWrite(4'h8, v);
    mInjOff = v[23:0];
  endtask

  task automatic memWrite(input int a, input logic [NB-1:0] be, input logic [DW-1:0] d);
    logic [23:0] off;
    off = 24'(a) << 2;
    @(negedge clk);
    memEn = 1; memWr = 1; memAddr = AW'(a); memBe = be; memWdata = d;
    @(negedge clk);
    memEn = 0; memWr = 0; memBe = 0;
    for (int b = 0; b < NB; b++) begin
      if (be[b]) begin
        refData[a][b*8 +: 8] = d[b*8 +: 8];
        refBad[a][b] = mInj && (off == mInjOff);
      end
    end
  endtask

  task automatic readCheck(input int a, input string tag);
    logic [31:0] r;
    logic expErr;
    expErr = |refBad[a];
    @(negedge clk);
    memEn = 1; memWr = 0; memAddr = AW'(a);
    @(negedge clk);
    memEn = 0;
    check(memRdata == refData[a], {tag, " data R4"}, memRdata, refData[a]);
    check(parErr == expErr, {tag, " error pulse"}, 32'(parErr), 32'(expErr));
    if (expErr && !mHold) mCapt = 24'(a) << 2;
    @(negedge clk);
    check(parErr == 1'b0, "R12 pulse one cycle", 32'(parErr), 0);
    regRead(4'h4, r);
    check(r == {8'h0, mCapt}, {tag, " capture R10"}, r, {8'h0, mCapt});
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int s);
    return (32'(a) * 32'h0103_0507) ^ (32'hA5C3_0F96 + 32'(s) * 32'h1111_1111);
  endfunction

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < DEPTH; i++) begin refData[i] = '0; refBad[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    regRead(4'h0, r); check(r == 0, "R1 control reset", r, 0);
    regRead(4'h4, r); check(r == 0, "R1 status reset", r, 0);
    regRead(4'h8, r); check(r == 0, "R1 injection reset", r, 0);
    check(parErr == 0, "R1 error low", 32'(parErr), 0);

    // R2 control field
    regWrite(4'h0, 32'hFFFF_FFFF); regRead(4'h0, r);
    check(r == 32'h0000_01FF, "R2 control all ones", r, 32'h1FF);
    regWrite(4'h0, 32'h0000_00FE); regRead(4'h0, r);
    check(r == 32'h0000_00FE, "R2 reserved bits hold", r, 32'hFE);
    setCtrl(32'h0);

    // R3 injection register, read-only status, unmapped
    regWrite(4'h8, 32'hFFFF_FFFF); regRead(4'h8, r);
    check(r == 32'h00FF_FFFF, "R3 injection width", r, 32'h00FF_FFFF);
    regWrite(4'h4, 32'h0012_3450); regRead(4'h4, r);
    check(r == 0, "R3 status read-only", r, 0);
    regRead(4'hC, r); check(r == 0, "R3 unmapped zero", r, 0);
    setInj(32'h0);

    // R6 clean fill, full sweep
    for (int a = 0; a < DEPTH; a++) memWrite(a, '1, pat(a, 1));
    for (int a = 0; a < DEPTH; a++) readCheck(a, "R6 clean");

    // R5 byte masks, every non-zero mask
    for (int a = 0; a < DEPTH; a++) memWrite(a, NB'((a % 15) + 1), pat(a, 2));
    for (int a = 0; a < DEPTH; a++) readCheck(a, "R5 masked");

    // R7 / R8 injection at chosen words, neighbours stay clean
    setCtrl(32'h1);
    for (int t = 0; t < DEPTH; t += 5) begin
      setInj(32'(t) << 2);
      memWrite(t, '1, pat(t, 3));
      memWrite((t + 1) % DEPTH, '1, pat(t + 1, 3));
      readCheck(t, "R7 injected");
      readCheck((t + 1) % DEPTH, "R8 neighbour");
    end
    // partial-lane injection, single capture for multi-lane fault
    setInj(32'd9 << 2);
    memWrite(9, 4'b0100, pat(9, 4));
    readCheck(9, "R7 one lane");
    memWrite(9, 4'b1011, pat(9, 5));
    readCheck(9, "R12 multi lane");
    // misaligned offset matches nothing
    setInj((32'd3 << 2) | 32'd1);
    memWrite(3, '1, pat(3, 6));
    readCheck(3, "R7 misaligned");

    // R9 persistence after disable, lane-wise clearing
    setCtrl(32'h0);
    readCheck(5, "R9 persists");
    memWrite(5, 4'b0011, pat(5, 7));
    readCheck(5, "R9 partial rewrite");
    memWrite(5, 4'b1100, pat(5, 8));
    readCheck(5, "R9 cleared");

    // R11 capture hold: pulse still seen, status frozen
    setCtrl(32'h100);
    readCheck(0, "R11 hold word0");
    readCheck(9, "R11 hold word9");
    setCtrl(32'h0);
    readCheck(10, "R10 release");

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule